// File: doc/BRIEF.md
# Parity-Steered Gray Code Counter

This block is an N-bit up-counter whose output walks the reflected binary Gray sequence, so exactly one output bit changes on each counted clock edge. There is no binary state behind the main output. The Gray bits sit in registers next to a single hidden parity flip-flop, and that flip-flop divides the count by two. All registers share one clock edge. Combinational gating decides which Gray bit flips on each edge.

When the parity is even, bit 0 flips. When the parity is odd, the gating finds the lowest set Gray bit and flips the bit just above it. The one exception is the state where only the top bit is set. There the top bit itself flips, and the count wraps to zero.

An optional second output carries the same sequence a different way. A plain binary counter advances on the same enable, its value is recoded to Gray with XORs, and the result is registered once more. This output trails the main output by one cycle. Users who need a glitch-free registered Gray value next to a binary-derived one can compare the two outputs directly.

Top module: `gray_step_counter`

## Requirements
- R1: While `rst_n` is low, `gray_o` and `gray_reg_o` are zero and the hidden parity is cleared, so the first enabled edge after reset yields `gray_o` = 1.
- R2: Every rising edge with `count_en` high changes exactly one bit of `gray_o`.
- R3: A rising edge with `count_en` low leaves `gray_o` unchanged.
- R4: Bit 0 of `gray_o` flips on the 1st, 3rd, 5th, ... enabled edge after reset and on no other enabled edge. The XOR of all bits of `gray_o` equals the hidden parity bit.
- R5: On the 2nd, 4th, ... enabled edge, the bit that flips is the one directly above the lowest set bit of `gray_o`.
- R6: When `gray_o` has only bit WIDTH-1 set and an odd number of enabled edges has occurred, the next enabled edge returns `gray_o` to zero. The sequence has 2^WIDTH distinct states.
- R7: `gray_o` always equals b ^ (b >> 1), where b is the number of enabled edges since reset, modulo 2^WIDTH.
- R8: With EXPOSE_RECODED = 1, `gray_reg_o` equals the value `gray_o` had one clock earlier. With EXPOSE_RECODED = 0, `gray_reg_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| count_en | input | 1 | Advance the count on this edge |
| gray_o | output | WIDTH | Gray count held in the parity-steered registers |
| gray_reg_o | output | WIDTH | Gray count recoded from a binary counter and registered, one cycle late |

## Verification
A corrupted parity bit, or a wrong gating term, shows at the ports on the very next enabled edge. Either two bits of `gray_o` change, or the wrong bit flips, and `gray_o` leaves the b ^ (b >> 1) sequence at once. A fault in the binary path shows as a mismatch between `gray_reg_o` and the one-cycle-delayed `gray_o` within one cycle of the faulty count. A wrap fault shows the first time the top-bit-only state is passed.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  // Which class of bit moves on the coming edge.
  typedef enum logic {
    STEP_LOW  = 1'b0,   // parity even: bit 0 flips
    STEP_HIGH = 1'b1    // parity odd : bit above lowest set bit flips
  } step_kind_e;

endpackage

// File: rtl/gsc_parity.sv
module gsc_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output gsc_pkg::step_kind_e kind_o
);
  import gsc_pkg::*;

  logic par_q;
  logic par_d;

  always_comb begin
    par_d = par_q;
    if (adv) begin
      par_d = ~par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
    end else begin
      par_q <= par_d;
    end
  end

  assign kind_o = step_kind_e'(par_q);

endmodule

// File: rtl/gsc_gray_core.sv
module gsc_gray_core #(
  parameter int WIDTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  gsc_pkg::step_kind_e kind_i,
  output logic [WIDTH-1:0]    gray_o
);
  import gsc_pkg::*;

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] gray_q;
  logic [WIDTH-1:0] gray_d;
  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] below_clear;   // below_clear[i]: bits i-1..0 are all zero
  logic             hi_step;

  assign hi_step = (kind_i == STEP_HIGH);

  assign below_clear[0] = 1'b1;
  assign flip[0]        = ~hi_step;

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_clear
      assign below_clear[gi] = below_clear[gi-1] & ~gray_q[gi-1];
    end

    for (gi = 1; gi < TOP; gi++) begin : g_mid
      assign flip[gi] = hi_step & gray_q[gi-1] & below_clear[gi-1];
    end
  endgenerate

  // Top bit: flips when the bit below it is the lowest set bit, or when it is
  // the only set bit (wrap back to zero).
  assign flip[TOP] = hi_step &
                     ((gray_q[TOP-1] & below_clear[TOP-1]) |
                      (gray_q[TOP]   & below_clear[TOP]));

  always_comb begin
    gray_d = gray_q;
    if (adv) begin
      gray_d = gray_q ^ flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= '0;
    end else begin
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;

endmodule

// File: rtl/gsc_bin_recode.sv
module gsc_bin_recode #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WIDTH-1:0] gray_reg_o
);

  logic [WIDTH-1:0] bin_q;
  logic [WIDTH-1:0] bin_d;
  logic [WIDTH-1:0] recoded;
  logic [WIDTH-1:0] out_q;

  always_comb begin
    bin_d = bin_q;
    if (adv) begin
      bin_d = bin_q + {{(WIDTH-1){1'b0}}, 1'b1};
    end
  end

  assign recoded = bin_q ^ (bin_q >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      out_q <= '0;
    end else begin
      bin_q <= bin_d;
      out_q <= recoded;
    end
  end

  assign gray_reg_o = out_q;

endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter #(
  parameter int WIDTH          = 4,
  parameter bit EXPOSE_RECODED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  output logic [WIDTH-1:0] gray_o,
  output logic [WIDTH-1:0] gray_reg_o
);
  import gsc_pkg::*;

  step_kind_e kind;
  logic       parity_q;

  gsc_parity u_parity (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (count_en),
    .kind_o (kind)
  );

  assign parity_q = logic'(kind);

  gsc_gray_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (count_en),
    .kind_i (kind),
    .gray_o (gray_o)
  );

  generate
    if (EXPOSE_RECODED) begin : g_recode
      gsc_bin_recode #(.WIDTH(WIDTH)) u_recode (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (count_en),
        .gray_reg_o (gray_reg_o)
      );
    end else begin : g_no_recode
      assign gray_reg_o = '0;
    end
  endgenerate

endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int WIDTH          = 4,
  parameter bit EXPOSE_RECODED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic [WIDTH-1:0] gray_o,
  input logic [WIDTH-1:0] gray_reg_o,
  input logic             parity
);

  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (gray_o == '0 && gray_reg_o == '0 && parity == 1'b0));

  assert_one_bit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && count_en |=> $countones(gray_o ^ $past(gray_o)) == 1);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !count_en |=> $stable(gray_o));

  assert_parity_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (^gray_o) == parity);

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && count_en && gray_o == TOP_ONLY |=> gray_o == '0);

  generate
    if (EXPOSE_RECODED) begin : g_chk_recode
      assert_recode_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> gray_reg_o == $past(gray_o));
    end else begin : g_chk_none
      assert_recode_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gray_reg_o == '0);
    end
  endgenerate

endmodule

bind gray_step_counter gsc_checker #(
  .WIDTH          (WIDTH),
  .EXPOSE_RECODED (EXPOSE_RECODED)
) u_gsc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_en   (count_en),
  .gray_o     (gray_o),
  .gray_reg_o (gray_reg_o),
  .parity     (parity_q)
);

// File: tb/test_gray_step_counter.sv
`timescale 1ns/1ps
module test_gray_step_counter;

  localparam int W = 4;
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  logic         clk;
  logic         rst_n;
  logic         count_en;
  logic [W-1:0] gray_o;
  logic [W-1:0] gray_reg_o;

  int           n_tests;
  int           n_fail;
  logic [W-1:0] ref_bin;
  logic [W-1:0] prev_gray;
  bit           done;

  gray_step_counter #(.WIDTH(W), .EXPOSE_RECODED(1'b1)) i_gray_step_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en   (count_en),
    .gray_o     (gray_o),
    .gray_reg_o (gray_reg_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic int lowest_set(input logic [W-1:0] g);
    for (int i = 0; i < W; i++) begin
      if (g[i]) return i;
    end
    return -1;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    count_en = 1'b0;
    #1;
    check("R1 gray_o in reset", gray_o, '0);
    check("R1 gray_reg_o in reset", gray_reg_o, '0);
    @(negedge clk);
    rst_n     = 1'b1;
    ref_bin   = '0;
    prev_gray = '0;
  endtask

  // Drive count_en for one edge, then check outputs 1 ns after the edge.
  task automatic step(input bit en);
    logic [W-1:0] g_before;
    logic [W-1:0] bin_before;
    logic [W-1:0] diff;
    logic [W-1:0] want_flip;
    int           ls;
    @(negedge clk);
    count_en   = en;
    g_before   = gray_o;
    bin_before = ref_bin;
    @(posedge clk);
    #1;
    if (en) ref_bin = ref_bin + 1'b1;
    diff = gray_o ^ g_before;
    check("R7 gray equals b^(b>>1)", gray_o, to_gray(ref_bin));
    check("R8 recoded output one cycle late", gray_reg_o, prev_gray);
    if (!en) begin
      check("R3 hold when idle", gray_o, g_before);
    end else begin
      check("R2 one-bit change", W'($countones(diff)), W'(1));
      if (bin_before[0] == 1'b0) begin
        check("R4 bit0 flips on odd count", diff, W'(1));
      end else if (g_before == TOP_ONLY) begin
        check("R6 wrap to zero", gray_o, '0);
      end else begin
        ls = lowest_set(g_before);
        want_flip = '0;
        if (ls >= 0) want_flip[ls+1] = 1'b1;
        check("R5 bit above lowest set", diff, want_flip);
      end
    end
    prev_gray = gray_o;
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    count_en = 1'b0;
    ref_bin = '0;
    prev_gray = '0;
    void'($urandom(32'd20240611));

    do_reset();

    // R1: first enabled edge after reset gives 1.
    step(1'b1);
    check("R1 first count is 1", gray_o, W'(1));

    // Directed: full cycles to cover R6 wrap and R6 period.
    for (int k = 1; k < 2 * (1 << W); k++) step(1'b1);
    check("R6 period returns to zero", gray_o, '0);

    // Directed idle run.
    for (int k = 0; k < 5; k++) step(1'b0);

    // Mid-run reset.
    for (int k = 0; k < 7; k++) step(1'b1);
    do_reset();
    step(1'b1);
    check("R1 parity cleared by reset", gray_o, W'(1));

    // Constrained random enable, about 60% duty.
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 10) < 6);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule